// File: doc/BRIEF.md
# Coprocessor-0 High-Word Move Unit

This unit carries out the two privileged move instructions that read or write bits above bit 31 of four control registers that have been widened to 64 bits: two page-table entry halves (EntryLo0, EntryLo1), the load-linked address (LLAddr) and the cache tag (TagLo). Each cycle it takes one instruction word, qualified by a valid bit, together with the general-register source value. A read returns its result to the general-register file as a one-cycle write pulse. A write updates the target register. If the feature is switched off, either instruction raises a one-cycle reserved-instruction exception instead.

A parameter picks a 32-bit or a 64-bit datapath. In 64-bit mode the entry-low high word sits two bits lower (bits 61:30), and read results are sign-extended from 32 bits. Write data is trimmed by the physical-address mask. LLAddr cannot be written, and its read applies a configurable extra right shift.

The unit is a small state machine with four states. ST_IDLE means nothing to report. ST_RDRESP presents a register-file write. ST_TRAP presents the exception. ST_WRDONE means a write instruction retired with no output. Every state is re-entered from any state, one instruction per cycle: a valid high-word read with a nonzero destination goes to ST_RDRESP, an instruction while the feature bit is clear goes to ST_TRAP, an accepted write goes to ST_WRDONE, and anything else goes to ST_IDLE.

Top module: `cop0_hiword_unit`

## Requirements
- R1: An instruction is recognised only when bits 31:26 are 010000, bits 25:21 are 00010 (high read) or 00110 (high write) and bits 10:3 are all zero. Anything else produces no output and changes no register.
- R2: With `cfg_hiword_en` low, a recognised instruction pulses `ri_excpt` in the next cycle, issues no register-file write and changes no register.
- R3: A recognised read with the feature enabled pulses `gpr_we` in the next cycle, with `gpr_waddr` equal to instruction bits 20:16 and the result on `gpr_wdata`. A read whose destination field is 0 issues no write.
- R4: With `lpa_en` low, a read returns zero and a write has no effect.
- R5: The register number is bits 15:11 and the select is bits 2:0. Supported pairs are 2/0 (EntryLo0), 3/0 (EntryLo1), 17/0 (LLAddr) and 28 with select 0, 2, 4 or 6 (TagLo). Any other pair reads as zero and ignores writes.
- R6: Write data is source bits 31:0 ANDed with bits 31:0 of `pa_mask` shifted right by 36.
- R7: In 32-bit mode a write replaces bits 63:32 and keeps bits 31:0, and a read returns bits 63:32.
- R8: In 64-bit mode an entry-low write deposits the 32-bit value at bits 61:30, and a read returns bits 61:30 sign-extended to 64 bits.
- R9: An LLAddr read returns bits 31:0 of the register shifted right by 32+`LL_SHIFT`, sign-extended in 64-bit mode. LLAddr writes are no-operations.
- R10: In 64-bit mode a TagLo access uses bits 63:32, and the read result is sign-extended.
- R11: After reset, `gpr_we`, `ri_excpt`, `gpr_waddr` and `gpr_wdata` are zero. EntryLo0, EntryLo1 and TagLo are zero, and LLAddr holds `LL_INIT`.
- R12: `gpr_we` and `ri_excpt` are single-cycle pulses, never high together, and stay low in a cycle that follows one with `instr_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| gpr_src | input | XLEN | Source general-register value |
| cfg_hiword_en | input | 1 | Feature enable; clear causes reserved-instruction exception |
| lpa_en | input | 1 | Large physical addressing enabled |
| pa_mask | input | 64 | Physical-address mask |
| gpr_we | output | 1 | Register-file write pulse |
| gpr_waddr | output | 5 | Destination register number |
| gpr_wdata | output | XLEN | Read result |
| ri_excpt | output | 1 | Reserved-instruction exception pulse |

## Verification
Every result is due exactly one clock after the edge that accepts its instruction. The write pulse, the exception pulse, the destination and the data all leave from the state and capture registers. A register update made by a write becomes visible to a read issued in the very next cycle. The bench drives each instruction at a falling edge and samples the outputs at the next falling edge, comparing them with a model stepped once per instruction. Two instances, one 32-bit and one 64-bit, share the same stimulus, and each is compared with its own model.

// File: rtl/cop0hw_pkg.sv
package cop0hw_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ELO0,
        TGT_ELO1,
        TGT_LLADDR,
        TGT_TAGLO
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDRESP,
        ST_TRAP,
        ST_WRDONE
    } st_e;

    localparam logic [5:0] OPC_COP0   = 6'b010000;
    localparam logic [4:0] FN_RDHI    = 5'h02;
    localparam logic [4:0] FN_WRHI    = 5'h06;
    localparam logic [4:0] REG_ELO0   = 5'd2;
    localparam logic [4:0] REG_ELO1   = 5'd3;
    localparam logic [4:0] REG_LLADDR = 5'd17;
    localparam logic [4:0] REG_TAGLO  = 5'd28;

endpackage

// File: rtl/cop0hw_decode.sv
module cop0hw_decode
    import cop0hw_pkg::*;
(
    input  logic [31:0] instr,
    output logic        is_rd,
    output logic        is_wr,
    output logic [4:0]  rt,
    output tgt_e        tgt
);

    logic       base_ok;
    logic [4:0] fn;
    logic [4:0] regno;
    logic [2:0] sel;

    always_comb begin
        fn      = instr[25:21];
        rt      = instr[20:16];
        regno   = instr[15:11];
        sel     = instr[2:0];
        base_ok = (instr[31:26] == OPC_COP0) && (instr[10:3] == 8'h00);
        is_rd   = base_ok && (fn == FN_RDHI);
        is_wr   = base_ok && (fn == FN_WRHI);

        tgt = TGT_NONE;
        if (regno == REG_ELO0 && sel == 3'd0)        tgt = TGT_ELO0;
        else if (regno == REG_ELO1 && sel == 3'd0)   tgt = TGT_ELO1;
        else if (regno == REG_LLADDR && sel == 3'd0) tgt = TGT_LLADDR;
        else if (regno == REG_TAGLO && !sel[0])      tgt = TGT_TAGLO;
    end

endmodule

// File: rtl/cop0hw_regfile.sv
module cop0hw_regfile
    import cop0hw_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          LL_SHIFT = 4,
    parameter logic [63:0] LL_INIT  = 64'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  tgt_e            tgt,
    input  logic [31:0]     wr_val,
    output logic [XLEN-1:0] rd_val
);

    localparam int ELO_LSB = (XLEN == 64) ? 30 : 32;
    localparam int LL_LSB  = 32 + LL_SHIFT;

    logic [63:0] elo0_q, elo1_q, taglo_q, lladdr_q;
    logic [63:0] ll_shr;
    logic [31:0] word;
    logic        unused_rf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elo0_q   <= 64'h0;
            elo1_q   <= 64'h0;
            taglo_q  <= 64'h0;
            lladdr_q <= LL_INIT;
        end else begin
            lladdr_q <= lladdr_q;
            if (wr_en) begin
                unique case (tgt)
                    TGT_ELO0:  elo0_q[ELO_LSB +: 32]  <= wr_val;
                    TGT_ELO1:  elo1_q[ELO_LSB +: 32]  <= wr_val;
                    TGT_TAGLO: taglo_q[63:32]         <= wr_val;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ll_shr = lladdr_q >> LL_LSB;
        unique case (tgt)
            TGT_ELO0:   word = elo0_q[ELO_LSB +: 32];
            TGT_ELO1:   word = elo1_q[ELO_LSB +: 32];
            TGT_LLADDR: word = ll_shr[31:0];
            TGT_TAGLO:  word = taglo_q[63:32];
            default:    word = 32'h0;
        endcase
    end

    generate
        if (XLEN == 64) begin : g_sext
            assign rd_val = {{(XLEN-32){word[31]}}, word};
        end else begin : g_narrow
            assign rd_val = word;
        end
    endgenerate

    assign unused_rf = ^{elo0_q, elo1_q, taglo_q, ll_shr};

endmodule

// File: rtl/cop0_hiword_unit.sv
module cop0_hiword_unit
    import cop0hw_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          LL_SHIFT = 4,
    parameter logic [63:0] LL_INIT  = 64'hF123_4567_89AB_CDEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] gpr_src,
    input  logic            cfg_hiword_en,
    input  logic            lpa_en,
    input  logic [63:0]     pa_mask,
    output logic            gpr_we,
    output logic [4:0]      gpr_waddr,
    output logic [XLEN-1:0] gpr_wdata,
    output logic            ri_excpt
);

    st_e             state_q, state_d;
    logic            is_rd, is_wr;
    logic [4:0]      rt;
    tgt_e            tgt;
    logic            wr_en;
    logic            tgt_writable;
    logic [31:0]     wr_val;
    logic [XLEN-1:0] rd_val;
    logic [4:0]      rt_q;
    logic [XLEN-1:0] data_q;
    logic            unused_top;

    cop0hw_decode u_dec (
        .instr (instr),
        .is_rd (is_rd),
        .is_wr (is_wr),
        .rt    (rt),
        .tgt   (tgt)
    );

    always_comb begin
        tgt_writable = (tgt == TGT_ELO0) || (tgt == TGT_ELO1) || (tgt == TGT_TAGLO);
        wr_val       = gpr_src[31:0] & {4'h0, pa_mask[63:36]};
        wr_en        = instr_valid && is_wr && cfg_hiword_en && lpa_en && tgt_writable;
    end

    cop0hw_regfile #(
        .XLEN     (XLEN),
        .LL_SHIFT (LL_SHIFT),
        .LL_INIT  (LL_INIT)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .tgt    (tgt),
        .wr_val (wr_val),
        .rd_val (rd_val)
    );

    // Next-state decision
    always_comb begin
        if (!instr_valid || !(is_rd || is_wr)) state_d = ST_IDLE;
        else if (!cfg_hiword_en)               state_d = ST_TRAP;
        else if (is_rd)                        state_d = (rt != 5'd0) ? ST_RDRESP : ST_IDLE;
        else                                   state_d = ST_WRDONE;
    end

    // State and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rt_q    <= 5'd0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RDRESP) begin
                rt_q   <= rt;
                data_q <= lpa_en ? rd_val : '0;
            end
        end
    end

    // Outputs from state
    always_comb begin
        gpr_we    = 1'b0;
        gpr_waddr = 5'd0;
        gpr_wdata = '0;
        ri_excpt  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RDRESP: begin
                gpr_we    = 1'b1;
                gpr_waddr = rt_q;
                gpr_wdata = data_q;
            end
            ST_TRAP:   ri_excpt = 1'b1;
            ST_WRDONE: ;
        endcase
    end

    assign unused_top = ^{pa_mask[35:0], gpr_src};

endmodule

// File: rtl/cop0hw_checks.sv
module cop0hw_checks #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            instr_valid,
    input logic [31:0]     instr,
    input logic            cfg_hiword_en,
    input logic            lpa_en,
    input logic            gpr_we,
    input logic [4:0]      gpr_waddr,
    input logic [XLEN-1:0] gpr_wdata,
    input logic            ri_excpt
);

    logic hw_op, rd_op;
    assign hw_op = (instr[31:26] == 6'h10) && (instr[10:3] == 8'h00) &&
                   ((instr[25:21] == 5'h02) || (instr[25:21] == 5'h06));
    assign rd_op = hw_op && (instr[25:21] == 5'h02);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_we && ri_excpt));

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!gpr_we && !ri_excpt));

    a_r1_nomatch: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !hw_op) |=> (!gpr_we && !ri_excpt));

    a_r2_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && hw_op && !cfg_hiword_en) |=> (ri_excpt && !gpr_we));

    a_r3_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && rd_op && cfg_hiword_en && instr[20:16] != 5'd0)
        |=> (gpr_we && gpr_waddr == $past(instr[20:16])));

    a_r3_nozero: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_we |-> (gpr_waddr != 5'd0));

    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && rd_op && cfg_hiword_en && !lpa_en && instr[20:16] != 5'd0)
        |=> (gpr_we && gpr_wdata == '0));

endmodule

bind cop0_hiword_unit cop0hw_checks #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr         (instr),
    .cfg_hiword_en (cfg_hiword_en),
    .lpa_en        (lpa_en),
    .gpr_we        (gpr_we),
    .gpr_waddr     (gpr_waddr),
    .gpr_wdata     (gpr_wdata),
    .ri_excpt      (ri_excpt)
);

// File: tb/sim_cop0_hiword_unit.sv
module sim_cop0_hiword_unit;

    localparam int          SH  = 4;
    localparam logic [63:0] LLI = 64'hF123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0;
    logic [31:0] ins = 32'h0;
    logic [63:0] src = 64'h0;
    logic        mvh = 1'b0;
    logic        lpa = 1'b0;
    logic [63:0] pam = 64'h0;

    logic        we0, ri0, we1, ri1;
    logic [4:0]  wa0, wa1;
    logic [31:0] wd0;
    logic [63:0] wd1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] mreg [2][4];

    always #5 clk = ~clk;

    cop0_hiword_unit #(.XLEN(32), .LL_SHIFT(SH), .LL_INIT(LLI)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(v), .instr(ins), .gpr_src(src[31:0]),
        .cfg_hiword_en(mvh), .lpa_en(lpa), .pa_mask(pam),
        .gpr_we(we0), .gpr_waddr(wa0), .gpr_wdata(wd0), .ri_excpt(ri0));

    cop0_hiword_unit #(.XLEN(64), .LL_SHIFT(SH), .LL_INIT(LLI)) u1 (
        .clk(clk), .rst_n(rst_n), .instr_valid(v), .instr(ins), .gpr_src(src),
        .cfg_hiword_en(mvh), .lpa_en(lpa), .pa_mask(pam),
        .gpr_we(we1), .gpr_waddr(wa1), .gpr_wdata(wd1), .ri_excpt(ri1));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [2:0] sel);
        return {6'h10, rs, rt, rd, 8'h00, sel};
    endfunction

    function automatic int tgt_of(input logic [31:0] w);
        if (w[15:11] == 5'd2 && w[2:0] == 3'd0)  return 0;
        if (w[15:11] == 5'd3 && w[2:0] == 3'd0)  return 1;
        if (w[15:11] == 5'd17 && w[2:0] == 3'd0) return 2;
        if (w[15:11] == 5'd28 && !w[0])          return 3;
        return -1;
    endfunction

    function automatic logic [63:0] rd_model(input int m, input int tg);
        logic [63:0] r, s;
        logic [31:0] w;
        r = mreg[m][tg];
        case (tg)
            0, 1:    w = (m == 1) ? r[61:30] : r[63:32];
            2:       begin s = r >> (32 + SH); w = s[31:0]; end
            default: w = r[63:32];
        endcase
        return (m == 1) ? {{32{w[31]}}, w} : {32'h0, w};
    endfunction

    // one instruction: drive at negedge, result checked at the next negedge
    task automatic step(input logic iv, input logic [31:0] iw, input logic [63:0] is,
                        input logic im, input logic il, input logic [63:0] ip);
        logic        match, rdop;
        int          tg;
        logic        e_we [2];
        logic        e_ri [2];
        logic [63:0] e_d  [2];
        logic [63:0] pm;
        logic [31:0] wv;
        string       tag;
        v = iv; ins = iw; src = is; mvh = im; lpa = il; pam = ip;
        match = iw[31:26] == 6'h10 && iw[10:3] == 8'h00 &&
                (iw[25:21] == 5'h02 || iw[25:21] == 5'h06);
        rdop = match && iw[25:21] == 5'h02;
        tg = tgt_of(iw);
        pm = ip >> 36;
        wv = is[31:0] & pm[31:0];
        for (int m = 0; m < 2; m++) begin
            e_we[m] = 1'b0; e_ri[m] = 1'b0; e_d[m] = 64'h0;
            if (iv && match) begin
                if (!im) e_ri[m] = 1'b1;
                else if (rdop) begin
                    if (iw[20:16] != 5'd0) begin
                        e_we[m] = 1'b1;
                        if (il && tg >= 0) e_d[m] = rd_model(m, tg);
                    end
                end else if (il && tg >= 0 && tg != 2) begin
                    if (m == 1 && tg < 2) mreg[m][tg][61:30] = wv;
                    else                  mreg[m][tg][63:32] = wv;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            if (!iv) tag = "R12";
            else if (!match) tag = "R1";
            else if (!im) tag = "R2";
            else if (rdop && iw[20:16] == 5'd0) tag = "R3";
            else if (!il) tag = "R4";
            else if (tg < 0) tag = "R5";
            else if (tg == 2) tag = "R9";
            else if (!rdop) tag = "R6";
            else if (m == 1 && tg < 2) tag = "R8";
            else if (m == 1) tag = "R10";
            else tag = "R7";
            tag = $sformatf("%s u%0d", tag, m);
            if (m == 0) begin
                chk(we0 == e_we[0], {tag, " we"}, 64'(we0), 64'(e_we[0]));
                chk(ri0 == e_ri[0], {tag, " ri"}, 64'(ri0), 64'(e_ri[0]));
                if (e_we[0]) begin
                    chk(wa0 == iw[20:16], {tag, " waddr"}, 64'(wa0), 64'(iw[20:16]));
                    chk(wd0 == e_d[0][31:0], {tag, " data"}, 64'(wd0), e_d[0]);
                end
            end else begin
                chk(we1 == e_we[1], {tag, " we"}, 64'(we1), 64'(e_we[1]));
                chk(ri1 == e_ri[1], {tag, " ri"}, 64'(ri1), 64'(e_ri[1]));
                if (e_we[1]) begin
                    chk(wa1 == iw[20:16], {tag, " waddr"}, 64'(wa1), 64'(iw[20:16]));
                    chk(wd1 == e_d[1], {tag, " data"}, wd1, e_d[1]);
                end
            end
        end
    endtask

    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        logic [4:0]  rdn;
        logic [31:0] iw;
        logic [63:0] ip;
        int          r;
        void'($urandom(32'd2718));
        for (int m = 0; m < 2; m++) begin
            mreg[m][0] = 64'h0; mreg[m][1] = 64'h0; mreg[m][2] = LLI; mreg[m][3] = 64'h0;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!we0 && !ri0 && wa0 == 5'd0 && wd0 == 32'h0, "R11 u0 reset", {we0, ri0, wa0, wd0}, 64'h0);
        chk(!we1 && !ri1 && wa1 == 5'd0 && wd1 == 64'h0, "R11 u1 reset", {we1, ri1, wa1}, 64'h0);
        rst_n = 1'b1;
        // R11 registers read back zero after reset
        step(1, mk(5'h02, 5'd7, 5'd2, 3'd0), 0, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd8, 5'd28, 3'd4), 0, 1, 1, ALL1);
        // R7 R8 entry-low write and back-to-back read
        step(1, mk(5'h06, 5'd1, 5'd2, 3'd0), 64'h1234_5678_FFFF_FFFF, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd5, 5'd2, 3'd0), 0, 1, 1, ALL1);
        step(1, mk(5'h06, 5'd1, 5'd3, 3'd0), 64'h0000_0000_8000_0003, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd6, 5'd3, 3'd0), 0, 1, 1, ALL1);
        // R6 narrow mask, R10 TagLo select 6 then 2
        step(1, mk(5'h06, 5'd1, 5'd28, 3'd6), 64'hFFFF_FFFF, 1, 1, 64'h0000_0FFF_F000_0000);
        step(1, mk(5'h02, 5'd9, 5'd28, 3'd2), 0, 1, 1, ALL1);
        step(1, mk(5'h06, 5'd1, 5'd28, 3'd0), 64'h8765_4321, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd9, 5'd28, 3'd0), 0, 1, 1, ALL1);
        // R4 large addressing off
        step(1, mk(5'h02, 5'd4, 5'd2, 3'd0), 0, 1, 0, ALL1);
        step(1, mk(5'h06, 5'd1, 5'd2, 3'd0), 64'hAAAA_AAAA, 1, 0, ALL1);
        step(1, mk(5'h02, 5'd4, 5'd2, 3'd0), 0, 1, 1, ALL1);
        // R2 feature disabled
        step(1, mk(5'h02, 5'd4, 5'd2, 3'd0), 0, 0, 1, ALL1);
        step(1, mk(5'h06, 5'd0, 5'd2, 3'd0), 64'h5555_5555, 0, 1, ALL1);
        step(1, mk(5'h02, 5'd0, 5'd2, 3'd0), 0, 0, 1, ALL1);
        step(1, mk(5'h02, 5'd4, 5'd2, 3'd0), 0, 1, 1, ALL1);
        // R3 destination zero
        step(1, mk(5'h02, 5'd0, 5'd28, 3'd0), 0, 1, 1, ALL1);
        // R9 LLAddr read and ignored write
        step(1, mk(5'h02, 5'd31, 5'd17, 3'd0), 0, 1, 1, ALL1);
        step(1, mk(5'h06, 5'd1, 5'd17, 3'd0), 64'h1111_1111, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd31, 5'd17, 3'd0), 0, 1, 1, ALL1);
        // R5 unsupported pairs
        step(1, mk(5'h06, 5'd1, 5'd3, 3'd1), 64'hFFFF_FFFF, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd2, 5'd3, 3'd0), 0, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd2, 5'd5, 3'd0), 0, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd2, 5'd28, 3'd3), 0, 1, 1, ALL1);
        // R1 nonzero bits 10:3, wrong major opcode
        step(1, mk(5'h06, 5'd1, 5'd2, 3'd0) | 32'h0000_0100, 64'h0F0F_0F0F, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd3, 5'd2, 3'd0) ^ 32'h8000_0000, 0, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd3, 5'd2, 3'd0), 0, 1, 1, ALL1);
        // R12 invalid cycle ignored
        step(0, mk(5'h06, 5'd1, 5'd2, 3'd0), 64'h0BAD_0BAD, 1, 1, ALL1);
        step(1, mk(5'h02, 5'd3, 5'd2, 3'd0), 0, 1, 1, ALL1);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom_range(0, 4));
            case (r)
                0: rdn = 5'd2; 1: rdn = 5'd3; 2: rdn = 5'd17; 3: rdn = 5'd28;
                default: rdn = 5'($urandom);
            endcase
            iw = mk(($urandom_range(0, 1) == 1) ? 5'h02 : 5'h06, 5'($urandom), rdn,
                    ($urandom_range(0, 2) == 0) ? 3'($urandom) : 3'd0);
            if ($urandom_range(0, 19) == 0) iw[10:3] = 8'($urandom);
            if ($urandom_range(0, 29) == 0) iw[25:21] = 5'($urandom);
            r = int'($urandom_range(0, 2));
            ip = (r == 0) ? ALL1 : (r == 1) ? 64'h0000_FFFF_FFFF_FFFF : {$urandom, $urandom};
            step($urandom_range(0, 9) != 0, iw, {$urandom, $urandom},
                 $urandom_range(0, 9) != 0, $urandom_range(0, 6) != 0, ip);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule